// File: doc/BRIEF.md
# Write-Protected BCD Calendar Register Bank

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of month, month, two-digit year, weekday and century in packed BCD registers. The registers sit behind a byte-wide synchronous register port of the kind found behind a serial-bus target. A one-second `tick` input advances the time. Each unit carries into the next, and the day count follows the month length, including leap years.

The calendar registers are write-protected. Software must first set a write-enable latch through the status register, then set a second register-write latch on top of it. Only then does a calendar write take effect. Any status write with the enable bit clear locks the bank again.

A clock-fail flag is raised at reset. It stays up until the first accepted calendar write, so software can tell that the time was never set. Reads have one cycle of latency. A read marked as the first of a burst takes its address from the port, and the reads that follow continue from an internal pointer that auto-increments.

Top module: `rtcb_core`

## Requirements
- R1: After reset the calendar bytes read seconds 0x00, minutes 0x00, hours 0x80 (24-hour mode bit set, hour 00), day 0x01, month 0x01, year 0x00, weekday 0x00, century 0x20, and the status register reads 0x01.
- R2: Calendar byte k (seconds=0, minutes=1, hours=2, day=3, month=4, year=5, weekday=6, century=7) is at address 0x30+k. The status register is at 0x3F with bit 0 = clock fail, bit 1 = write-enable latch, bit 2 = register-write latch, and its other bits read 0. Reads of any other address return 0x00. `rdata` updates on the clock edge that samples `rd_en` and holds until the next read.
- R3: A write to 0x30..0x37 while the two latches are not both set changes no calendar byte.
- R4: Writing 0x02 (bit 1 set, bit 2 clear) to the status register sets the write-enable latch and clears the register-write latch. Writing a value with bits 1 and 2 both set (0x06) then sets the register-write latch. The same 0x06 write sets nothing when the write-enable latch was not already set.
- R5: A status write with bit 1 clear (for example 0x00) clears both latches, and later calendar writes are ignored.
- R6: On a tick, seconds count BCD 00..59 and wrap into minutes, minutes wrap 59→00 into hours, and hours count 00..23 in bits 5:0 with bit 7 kept.
- R7: When hours wrap, the weekday advances 0..6 and wraps to 0. The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 28 for month 02, or 29 when the binary year value is divisible by 4; 31 otherwise. Month wraps 12→01 and carries into the year.
- R8: Year wraps 99→00 and increments the BCD century. The century does not change on a tick unless the year was 99.
- R9: The clock-fail flag (status bit 0) is 1 after reset and clears on the first accepted calendar write. Nothing else clears it.
- R10: A read with `rd_first`=1 returns the byte at `addr`. Each following read with `rd_first`=0 returns the byte at the previous read address plus one, so eight reads starting at 0x30 return the whole calendar in order.
- R11: If an accepted calendar write and a tick occur in the same cycle, the written value is stored and that tick is dropped for all bytes.
- R12: An accepted write stores the weekday as its low 3 bits with the upper bits zero, and stores hours with bit 6 forced to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | 8 | Register address for writes and for the first read of a burst |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_first | input | 1 | Marks the first read of a burst (use `addr` rather than the pointer) |
| rdata | output | 8 | Read data, registered |

## Verification
The hardest states to reach from the ports are the deep carry chains. The longest is a tick that ripples from seconds through the year into the century, and it only occurs at the very end of a year. Ticking there from reset would take billions of cycles, so the bench unlocks the bank and writes each calendar byte to one tick before a boundary. The directed boundaries are the year end, a leap and a non-leap February, and a 30-day month. Random traffic then mixes ticks, writes and out-of-order status writes, checking the lock protocol against a bench model.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;

    localparam int NREG      = 8;
    localparam int ST_FAIL   = 0;
    localparam int ST_WEL    = 1;
    localparam int ST_RWEL   = 2;
    localparam logic [7:0] HOUR_KEEP = 8'hBF;
    localparam logic [7:0] WDAY_KEEP = 8'h07;

    // first member is the most significant byte: index 0 = seconds
    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] wday;
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef logic [NREG-1:0][7:0] cal_arr_t;

    typedef enum logic [1:0] {
        ST_OP_LOCK,
        ST_OP_ARM,
        ST_OP_CONFIRM
    } st_op_e;

    function automatic st_op_e st_decode(input logic [1:0] en_bits);
        // en_bits = {bit2, bit1}
        case (en_bits)
            2'b01:   return ST_OP_ARM;
            2'b11:   return ST_OP_CONFIRM;
            default: return ST_OP_LOCK;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon,
                                              input logic [7:0] year);
        logic [6:0] ybin;
        ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] wr_keep(input logic [2:0] idx);
        case (idx)
            3'd2:    return HOUR_KEEP;
            3'd6:    return WDAY_KEEP;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtcb_lock.sv
module rtcb_lock
    import rtcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_we,
    input  logic [1:0] st_en_bits,
    input  logic       cal_wr,
    output logic       wel,
    output logic       rwel,
    output logic       fail
);
    st_op_e op;
    assign op = st_decode(st_en_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
            fail <= 1'b1;
        end else begin
            if (st_we) begin
                case (op)
                    ST_OP_ARM: begin
                        wel  <= 1'b1;
                        rwel <= 1'b0;
                    end
                    ST_OP_CONFIRM: begin
                        if (wel) rwel <= 1'b1;
                    end
                    default: begin
                        wel  <= 1'b0;
                        rwel <= 1'b0;
                    end
                endcase
            end
            if (cal_wr) fail <= 1'b0;
        end
    end
endmodule

// File: rtl/rtcb_calendar.sv
module rtcb_calendar
    import rtcb_pkg::*;
#(
    parameter logic [7:0] RST_CENT = 8'h20
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_stb,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output cal_t       cal_q
);
    cal_t     adv;
    cal_t     cal_d;
    cal_arr_t wr_arr;

    always_comb begin
        adv = cal_q;
        if (cal_q.sec >= 8'h59) begin
            adv.sec = 8'h00;
            if (cal_q.min >= 8'h59) begin
                adv.min = 8'h00;
                if (cal_q.hour[5:0] >= 6'h23) begin
                    adv.hour = {cal_q.hour[7], 7'h00};
                    adv.wday = (cal_q.wday >= 8'd6) ? 8'd0 : cal_q.wday + 8'd1;
                    if (cal_q.mday >= month_last(cal_q.mon, cal_q.year)) begin
                        adv.mday = 8'h01;
                        if (cal_q.mon >= 8'h12) begin
                            adv.mon = 8'h01;
                            if (cal_q.year >= 8'h99) begin
                                adv.year = 8'h00;
                                adv.cent = (cal_q.cent >= 8'h99) ? 8'h00 : bcd_inc(cal_q.cent);
                            end else begin
                                adv.year = bcd_inc(cal_q.year);
                            end
                        end else begin
                            adv.mon = bcd_inc(cal_q.mon);
                        end
                    end else begin
                        adv.mday = bcd_inc(cal_q.mday);
                    end
                end else begin
                    adv.hour = bcd_inc(cal_q.hour);
                end
            end else begin
                adv.min = bcd_inc(cal_q.min);
            end
        end else begin
            adv.sec = bcd_inc(cal_q.sec);
        end
    end

    always_comb begin
        wr_arr         = cal_arr_t'(cal_q);
        wr_arr[wr_idx] = wr_data & wr_keep(wr_idx);
        if (wr_stb)
            cal_d = cal_t'(wr_arr);
        else if (tick)
            cal_d = adv;
        else
            cal_d = cal_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= '{cent: RST_CENT, wday: 8'h00, year: 8'h00, mon: 8'h01,
                       mday: 8'h01, hour: 8'h80, min: 8'h00, sec: 8'h00};
        end else begin
            cal_q <= cal_d;
        end
    end
endmodule

// File: rtl/rtcb_readport.sv
module rtcb_readport
    import rtcb_pkg::*;
#(
    parameter logic [7:0] CAL_BASE  = 8'h30,
    parameter logic [7:0] STAT_ADDR = 8'h3F
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       rd_first,
    input  logic [7:0] addr,
    input  cal_t       cal,
    input  logic [7:0] status,
    output logic [7:0] rdata
);
    localparam logic [7:0] CAL_LAST = CAL_BASE + 8'(NREG - 1);

    logic [7:0] ptr;
    logic [7:0] ra;
    logic [7:0] pick;
    logic [2:0] ridx;
    cal_arr_t   arr;

    assign ra   = rd_first ? addr : ptr;
    assign ridx = ra[2:0] - CAL_BASE[2:0];
    assign arr  = cal_arr_t'(cal);

    always_comb begin
        if (ra >= CAL_BASE && ra <= CAL_LAST)
            pick = arr[ridx];
        else if (ra == STAT_ADDR)
            pick = status;
        else
            pick = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= 8'h00;
            rdata <= 8'h00;
        end else if (rd_en) begin
            ptr   <= ra + 8'd1;
            rdata <= pick;
        end
    end
endmodule

// File: rtl/rtcb_core.sv
module rtcb_core
    import rtcb_pkg::*;
#(
    parameter logic [7:0] CAL_BASE  = 8'h30,
    parameter logic [7:0] STAT_ADDR = 8'h3F,
    parameter logic [7:0] RST_CENT  = 8'h20
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       rd_first,
    output logic [7:0] rdata
);
    localparam logic [7:0] CAL_LAST = CAL_BASE + 8'(NREG - 1);

    logic       addr_in_cal;
    logic       unlocked;
    logic       cal_wr;
    logic       st_we;
    logic       wel;
    logic       rwel;
    logic       fail;
    logic [2:0] widx;
    logic [7:0] status;
    cal_t       cal_q;

    assign addr_in_cal = (addr >= CAL_BASE) && (addr <= CAL_LAST);
    assign unlocked    = wel && rwel;
    assign cal_wr      = wr_en && addr_in_cal && unlocked;
    assign st_we       = wr_en && (addr == STAT_ADDR);
    assign widx        = addr[2:0] - CAL_BASE[2:0];

    always_comb begin
        status          = 8'h00;
        status[ST_FAIL] = fail;
        status[ST_WEL]  = wel;
        status[ST_RWEL] = rwel;
    end

    rtcb_lock u_lock (
        .clk        (clk),
        .rst        (rst),
        .st_we      (st_we),
        .st_en_bits ({wdata[ST_RWEL], wdata[ST_WEL]}),
        .cal_wr     (cal_wr),
        .wel        (wel),
        .rwel       (rwel),
        .fail       (fail)
    );

    rtcb_calendar #(.RST_CENT(RST_CENT)) u_cal (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_stb  (cal_wr),
        .wr_idx  (widx),
        .wr_data (wdata),
        .cal_q   (cal_q)
    );

    rtcb_readport #(.CAL_BASE(CAL_BASE), .STAT_ADDR(STAT_ADDR)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_first (rd_first),
        .addr     (addr),
        .cal      (cal_q),
        .status   (status),
        .rdata    (rdata)
    );
endmodule

// File: rtl/rtcb_checker.sv
module rtcb_checker
    import rtcb_pkg::*;
#(
    parameter logic [7:0] CAL_BASE  = 8'h30,
    parameter logic [7:0] STAT_ADDR = 8'h3F
)(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       addr_in_cal,
    input logic       unlocked,
    input logic       wel,
    input logic       rwel,
    input logic       fail,
    input cal_t       cal_q
);
    p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr_in_cal && !unlocked && !tick) |=> $stable(cal_q));

    p_rwel_order_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rwel) |-> $past(wel));

    p_relock_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == STAT_ADDR && !wdata[ST_WEL]) |=> (!wel && !rwel));

    p_sec_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00));

    p_cent_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cal_q.year != 8'h99) |=> $stable(cal_q.cent));

    p_fail_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(fail) |-> $past(wr_en && addr_in_cal && unlocked));

    p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_en && unlocked && addr == CAL_BASE) |=> (cal_q.sec == $past(wdata)));
endmodule

bind rtcb_core rtcb_checker #(.CAL_BASE(CAL_BASE), .STAT_ADDR(STAT_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .addr_in_cal (addr_in_cal),
    .unlocked    (unlocked),
    .wel         (wel),
    .rwel        (rwel),
    .fail        (fail),
    .cal_q       (cal_q)
);

// File: tb/rtcb_core_tb.sv
`timescale 1ns/100ps
module rtcb_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_first = 1'b0;
    logic [7:0] rdata;

    int total = 0;
    int bad   = 0;

    // bench model
    logic [7:0] m [8];
    logic m_fail, m_wel, m_rwel;

    always #2.5 clk = ~clk;

    rtcb_core u_dut (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_first(rd_first), .rdata(rdata)
    );

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_of(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] stat_model();
        return {5'b0, m_rwel, m_wel, m_fail};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic model_tick();
        int s, mi, h, d, mo, y, c;
        s = b2i(m[0]); mi = b2i(m[1]); h = b2i(m[2] & 8'h3F);
        d = b2i(m[3]); mo = b2i(m[4]); y = b2i(m[5]); c = b2i(m[7]);
        s++;
        if (s >= 60) begin
            s = 0; mi++;
            if (mi >= 60) begin
                mi = 0; h++;
                if (h >= 24) begin
                    h = 0;
                    m[6] = (m[6] >= 8'd6) ? 8'd0 : m[6] + 8'd1;
                    if (d >= days_of(mo, y)) begin
                        d = 1; mo++;
                        if (mo > 12) begin
                            mo = 1; y++;
                            if (y > 99) begin y = 0; c = (c + 1) % 100; end
                        end
                    end else d++;
                end
            end
        end
        m[0] = i2b(s); m[1] = i2b(mi); m[2] = {m[2][7], 1'b0, i2b(h)[5:0]};
        m[3] = i2b(d); m[4] = i2b(mo); m[5] = i2b(y); m[7] = i2b(c);
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h30 && a <= 8'h37 && m_wel && m_rwel) begin
            if (a == 8'h32)      m[2] = d & 8'hBF;
            else if (a == 8'h36) m[6] = d & 8'h07;
            else                 m[a - 8'h30] = d;
            m_fail = 1'b0;
        end else if (a == 8'h3F) begin
            if (d[1] && !d[2]) begin m_wel = 1'b1; m_rwel = 1'b0; end
            else if (d[1] && d[2]) begin if (m_wel) m_rwel = 1'b1; end
            else begin m_wel = 1'b0; m_rwel = 1'b0; end
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic rd(input logic [7:0] a, input logic first, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_first = first; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; rd_first = 1'b0;
        v = rdata;
    endtask

    task automatic burst_check(input string req);
        logic [7:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(8'h30, (k == 0), v);
            check(req, v, m[k]);
        end
    endtask

    task automatic unlock();
        wr(8'h3F, 8'h02);
        wr(8'h3F, 8'h06);
    endtask

    task automatic set_all(input logic [7:0] v [8]);
        for (int k = 0; k < 8; k++) wr(8'h30 + 8'(k), v[k]);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] pre [8];
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h80; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h00; m[6] = 8'h00; m[7] = 8'h20;
        m_fail = 1'b1; m_wel = 1'b0; m_rwel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R10: reset values through a burst from 0x30
        burst_check("R1 R10 reset burst");
        rd(8'h3F, 1'b1, v);
        check("R1 R2 reset status", v, 8'h01);
        rd(8'h20, 1'b1, v);
        check("R2 unmapped read", v, 8'h00);

        // R3: locked write ignored
        wr(8'h30, 8'h42);
        rd(8'h30, 1'b1, v);
        check("R3 locked write", v, 8'h00);

        // R4: confirm without arm does not set the latch
        wr(8'h3F, 8'h06);
        rd(8'h3F, 1'b1, v);
        check("R4 out-of-order confirm", v, 8'h01);
        wr(8'h31, 8'h33);
        rd(8'h31, 1'b1, v);
        check("R4 write after bad unlock", v, 8'h00);

        // R4: proper unlock
        wr(8'h3F, 8'h02);
        rd(8'h3F, 1'b1, v);
        check("R4 arm step", v, 8'h03);
        wr(8'h3F, 8'h06);
        rd(8'h3F, 1'b1, v);
        check("R4 confirm step", v, 8'h07);

        // R9: first accepted write clears fail; R12 masks
        wr(8'h36, 8'hFF);
        rd(8'h36, 1'b1, v);
        check("R12 weekday mask", v, 8'h07);
        rd(8'h3F, 1'b1, v);
        check("R9 fail cleared", v, 8'h06);
        wr(8'h32, 8'hFF);
        rd(8'h32, 1'b1, v);
        check("R12 hour mask", v, 8'hBF);

        // R6 R7 R8: year end with century carry, 1999-12-31 23:59:59 wday 6
        pre = '{8'h59, 8'h59, 8'h80 | 8'h23, 8'h31, 8'h12, 8'h99, 8'h06, 8'h19};
        set_all(pre);
        do_tick();
        burst_check("R6 R7 R8 year end carry");

        // R7: leap February 2024
        pre = '{8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03, 8'h20};
        set_all(pre);
        do_tick();
        rd(8'h33, 1'b1, v);
        check("R7 leap feb day", v, 8'h29);
        rd(8'h34, 1'b0, v);
        check("R7 leap feb month", v, 8'h02);
        rd(8'h35, 1'b0, v);
        check("R10 pointer continues", v, 8'h24);

        // R7: non-leap February 2023
        wr(8'h35, 8'h23);
        wr(8'h33, 8'h28);
        wr(8'h32, 8'h23);
        wr(8'h31, 8'h59);
        wr(8'h30, 8'h59);
        do_tick();
        burst_check("R7 non-leap feb");

        // R7: 30-day month
        wr(8'h34, 8'h04);
        wr(8'h33, 8'h30);
        wr(8'h32, 8'h23);
        wr(8'h31, 8'h59);
        wr(8'h30, 8'h59);
        do_tick();
        burst_check("R7 april end");

        // R11: write and tick in the same cycle
        @(negedge clk);
        addr = 8'h30; wdata = 8'h10; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        model_write(8'h30, 8'h10);
        burst_check("R11 write beats tick");

        // R5: relock and verify writes ignored
        wr(8'h3F, 8'h00);
        rd(8'h3F, 1'b1, v);
        check("R5 relock status", v, 8'h00);
        wr(8'h31, 8'h12);
        rd(8'h31, 1'b1, v);
        check("R5 write after relock", v, m[1]);

        // random phase
        void'($urandom(32'd2024));
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0, 1, 2, 7: do_tick();
                3: begin
                    int k;
                    logic [7:0] d;
                    k = int'($urandom % 8);
                    case (k)
                        0, 1: d = i2b(int'($urandom % 60));
                        2:    d = {1'($urandom % 2), 1'b0, i2b(int'($urandom % 24))[5:0]};
                        3:    d = i2b(1 + int'($urandom % 28));
                        4:    d = i2b(1 + int'($urandom % 12));
                        6:    d = 8'($urandom % 7);
                        default: d = i2b(int'($urandom % 100));
                    endcase
                    wr(8'h30 + 8'(k), d);
                end
                4: begin
                    logic [7:0] sv [4];
                    sv = '{8'h00, 8'h02, 8'h06, 8'h04};
                    wr(8'h3F, sv[$urandom % 4]);
                end
                5: burst_check("R3 R4 R6 R7 random burst");
                default: begin
                    rd(8'h3F, 1'b1, v);
                    check("R4 R5 R9 random status", v, stat_model());
                end
            endcase
        end
        burst_check("R6 R7 final burst");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule